// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

The unpacker sits between a FIFO of 32-bit framebuffer words and the data pins of an LCD panel. It accepts one word at a time through a valid/ready handshake and emits it as one or more pixel beats on a 24-bit pixel bus. The number of beats per word and the bit arrangement of each beat depend on four settings:

- the stored colour depth, 16-bit RGB565 or 24-bit RGB888 held in a 32-bit word;
- the width of the panel bus, 8, 16, 18 or 24 bits;
- a flag that trims 8-bit colours to 6 bits;
- a byte-valid mask that says whether a 16-bit word carries one pixel or two.

One beat is sent per dot clock while downstream is ready. Settings that cannot be served raise an error flag and stop the intake of words.

Top module: `pix_unpacker`

## Requirements
- R1: After reset `pix_valid` is 0, and `word_ready` is 1 whenever the settings are valid.
- R2: `word_len` code 0 selects 16-bit pixels and code 3 selects 24-bit pixels. Codes 1 and 2 set `cfg_error`, hold `word_ready` at 0 and produce no pixel.
- R3: `bus_width` codes are 0 = 16-bit, 1 = 8-bit, 2 = 18-bit and 3 = 24-bit. Code 1 together with `word_len` 3 sets `cfg_error`. Code 1 with `word_len` 0 does not set it.
- R4: In 16-bit mode with `byte_mask` = 4'hF, a word yields two pixels: bits 15:0 first, then bits 31:16.
- R5: In 16-bit mode with any other `byte_mask` (4'h7 is the normal value), a word yields one pixel, taken from bits 15:0.
- R6: A 16-bit pixel has red in 15:11, green in 10:5 and blue in 4:0.
  - On the 16-bit bus it appears unchanged in `pix_data[15:0]`.
  - On the 18-bit bus it appears as `{6'b0, r, r[4], g, b, b[4]}`.
  - On the 24-bit bus it appears as `{r, r[4:2], g, g[5:4], b, b[4:2]}`.
- R7: On the 8-bit bus each 16-bit pixel takes two beats, low byte first, in `pix_data[7:0]`, with bits 23:8 at zero.
- R8: A 24-bit pixel has red in 23:16, green in 15:8 and blue in 7:0, and bits 31:24 are ignored. With `trim18` at 0 on the 24-bit bus, bits 23:0 appear unchanged. A word always yields one pixel, whatever `byte_mask` holds.
- R9: A 24-bit pixel is reduced to `{6'b0, R[5:0], G[5:0], B[5:0]}` when `trim18` is 1 or when the bus is 16 or 18 bits wide.
- R10: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid` and `pix_data` hold.
- R11: `word_ready` is 1 only when no beat is pending, or when the last beat of the current word is accepted in that cycle. A word offered then is shown in the very next cycle, without an idle cycle.
- R12: The settings are captured with each word. A change after a word is accepted does not alter that word's remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Word available from FIFO |
| word_data | input | 32 | Framebuffer word |
| word_ready | output | 1 | Word accepted this cycle when valid |
| word_len | input | 2 | Colour depth code (0 = 16-bit, 3 = 24-bit) |
| bus_width | input | 2 | Panel bus code (0 = 16, 1 = 8, 2 = 18, 3 = 24) |
| trim18 | input | 1 | Keep low six bits of each 8-bit colour |
| byte_mask | input | 4 | Byte-valid mask of the word |
| pix_valid | output | 1 | Pixel beat on `pix_data` |
| pix_ready | input | 1 | Downstream takes the beat |
| pix_data | output | 24 | Pixel beat, right aligned |
| cfg_error | output | 1 | Settings combination not supported |

## Verification
Two events can fall in one cycle: acceptance of the last beat of a word and intake of the next word. The bench provokes this by keeping a second word valid while the two halves of a two-pixel word drain with `pix_ready` held high. It then judges that `word_ready` stays low on the first half and rises on the second. It also checks that the new word's first pixel is on the bus in the next cycle. A separate test changes every setting right after a word is taken, and checks that the remaining half keeps the captured format.

// File: rtl/pix_unpacker.sv
module pix_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  output logic        word_ready,
  input  logic [1:0]  word_len,
  input  logic [1:0]  bus_width,
  input  logic        trim18,
  input  logic [3:0]  byte_mask,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [23:0] pix_data,
  output logic        cfg_error
);

  localparam logic [1:0] WL_16  = 2'd0;
  localparam logic [1:0] WL_24  = 2'd3;
  localparam logic [1:0] BUS_16 = 2'd0;
  localparam logic [1:0] BUS_8  = 2'd1;
  localparam logic [1:0] BUS_18 = 2'd2;
  localparam logic [1:0] BUS_24 = 2'd3;

  logic        full;
  logic [31:0] wrd;
  logic [1:0]  idx, lst;
  logic        m16, m_trim;
  logic [1:0]  m_bus;

  logic two_pix, two_byte, last, fire, take;

  assign cfg_error  = (word_len == 2'd1) || (word_len == 2'd2) ||
                      (word_len == WL_24 && bus_width == BUS_8);
  assign two_pix    = (word_len == WL_16) && (byte_mask == 4'hF);
  assign two_byte   = (word_len == WL_16) && (bus_width == BUS_8);
  assign last       = (idx == lst);
  assign pix_valid  = full;
  assign fire       = full && pix_ready;
  assign word_ready = !cfg_error && (!full || (pix_ready && last));
  assign take       = word_valid && word_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      wrd    <= '0;
      idx    <= '0;
      lst    <= '0;
      m16    <= 1'b0;
      m_bus  <= BUS_16;
      m_trim <= 1'b0;
    end else if (take) begin
      full   <= 1'b1;
      wrd    <= word_data;
      idx    <= '0;
      lst    <= {two_pix && two_byte, two_pix || two_byte};
      m16    <= (word_len == WL_16);
      m_bus  <= bus_width;
      m_trim <= trim18;
    end else if (fire) begin
      if (last) full <= 1'b0;
      else      idx  <= idx + 2'd1;
    end
  end

  logic [15:0] hw;
  logic [7:0]  bt;
  logic [4:0]  r5, b5;
  logic [5:0]  g6;

  assign hw = ((m_bus == BUS_8) ? idx[1] : idx[0]) ? wrd[31:16] : wrd[15:0];
  assign bt = idx[0] ? hw[15:8] : hw[7:0];
  assign r5 = hw[15:11];
  assign g6 = hw[10:5];
  assign b5 = hw[4:0];

  always_comb begin
    if (m16) begin
      case (m_bus)
        BUS_8:   pix_data = {16'b0, bt};
        BUS_16:  pix_data = {8'b0, hw};
        BUS_18:  pix_data = {6'b0, r5, r5[4], g6, b5, b5[4]};
        default: pix_data = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      endcase
    end else if (m_bus == BUS_24 && !m_trim) begin
      pix_data = wrd[23:0];
    end else begin
      pix_data = {6'b0, wrd[21:16], wrd[13:8], wrd[5:0]};
    end
  end

endmodule

// File: rtl/pix_unpacker_chk.sv
module pix_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [23:0] pix_data,
  input logic        cfg_error
);

  p_error_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !word_ready);

  p_error_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_error && !pix_valid) |=> !pix_valid);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  p_refill_at_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && word_ready) |-> pix_ready);

  p_pixel_needs_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(word_valid && word_ready));

endmodule

bind pix_unpacker pix_unpacker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .cfg_error(cfg_error)
);

// File: tb/pix_unpacker_test.sv
`timescale 1ns/1ps
module pix_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic [1:0]  word_len = 2'd0;
  logic [1:0]  bus_width = 2'd0;
  logic        trim18 = 1'b0;
  logic [3:0]  byte_mask = 4'hF;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [23:0] pix_data;
  logic        cfg_error;

  always #2.5 clk = ~clk;

  pix_unpacker uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .word_len(word_len), .bus_width(bus_width),
    .trim18(trim18), .byte_mask(byte_mask), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .cfg_error(cfg_error)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {wl[2], bus[2], trim, mask[4], word[32], beats[3], e0, e1, e2, e3}
  localparam int NV = 10;
  localparam logic [139:0] VEC [0:NV-1] = '{
    {2'd0, 2'd0, 1'b0, 4'hF, 32'hABCD1234, 3'd2, 24'h001234, 24'h00ABCD, 24'h0, 24'h0},       // R4 R6
    {2'd0, 2'd0, 1'b0, 4'h7, 32'hABCD1234, 3'd1, 24'h001234, 24'h0, 24'h0, 24'h0},            // R5
    {2'd0, 2'd2, 1'b0, 4'h7, 32'h00008410, 3'd1, 24'h021821, 24'h0, 24'h0, 24'h0},            // R6
    {2'd0, 2'd3, 1'b0, 4'h7, 32'h00008410, 3'd1, 24'h848284, 24'h0, 24'h0, 24'h0},            // R6
    {2'd0, 2'd1, 1'b0, 4'hF, 32'hABCD1234, 3'd4, 24'h000034, 24'h000012, 24'h0000CD, 24'h0000AB}, // R7
    {2'd0, 2'd1, 1'b0, 4'h7, 32'hABCD1234, 3'd2, 24'h000034, 24'h000012, 24'h0, 24'h0},       // R7
    {2'd3, 2'd3, 1'b0, 4'h7, 32'hFF123456, 3'd1, 24'h123456, 24'h0, 24'h0, 24'h0},            // R8
    {2'd3, 2'd3, 1'b1, 4'h7, 32'h99C57A81, 3'd1, 24'h005E81, 24'h0, 24'h0, 24'h0},            // R9
    {2'd3, 2'd2, 1'b0, 4'h7, 32'h99C57A81, 3'd1, 24'h005E81, 24'h0, 24'h0, 24'h0},            // R9
    {2'd3, 2'd0, 1'b1, 4'hF, 32'h99C57A81, 3'd1, 24'h005E81, 24'h0, 24'h0, 24'h0}             // R9 R8
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pix_valid after reset", {23'b0, pix_valid}, 24'd0);
    chk("R1 word_ready after reset", {23'b0, word_ready}, 24'd1);

    for (int v = 0; v < NV; v++) begin
      logic [139:0] e;
      e = VEC[v];
      @(negedge clk);
      word_len = e[139:138]; bus_width = e[137:136]; trim18 = e[135];
      byte_mask = e[134:131]; word_data = e[130:99];
      word_valid = 1'b1; pix_ready = 1'b0;
      @(negedge clk);
      word_valid = 1'b0;
      for (int k = 0; k < int'(e[98:96]); k++) begin
        chk($sformatf("R4-R9 vec%0d valid beat%0d", v, k), {23'b0, pix_valid}, 24'd1);
        chk($sformatf("R4-R9 vec%0d data beat%0d", v, k), pix_data, e[95 - 24*k -: 24]);
        pix_ready = 1'b1;
        @(negedge clk);
        pix_ready = 1'b0;
      end
      chk($sformatf("R5 R7 vec%0d beat count", v), {23'b0, pix_valid}, 24'd0);
    end

    // R2: unsupported depth codes
    @(negedge clk);
    word_len = 2'd1; bus_width = 2'd0; word_data = 32'h12345678; word_valid = 1'b1;
    #1;
    chk("R2 cfg_error code1", {23'b0, cfg_error}, 24'd1);
    chk("R2 word_ready code1", {23'b0, word_ready}, 24'd0);
    repeat (3) @(negedge clk);
    chk("R2 no pixel code1", {23'b0, pix_valid}, 24'd0);
    word_len = 2'd2; #1;
    chk("R2 cfg_error code2", {23'b0, cfg_error}, 24'd1);
    // R3: 8-bit bus with 24-bit pixels
    word_len = 2'd3; bus_width = 2'd1; #1;
    chk("R3 cfg_error bus8 depth24", {23'b0, cfg_error}, 24'd1);
    repeat (2) @(negedge clk);
    chk("R3 no pixel bus8 depth24", {23'b0, pix_valid}, 24'd0);
    word_len = 2'd0; #1;
    chk("R3 no error bus8 depth16", {23'b0, cfg_error}, 24'd0);
    word_valid = 1'b0; bus_width = 2'd0;

    // R10: stall holds the beat
    @(negedge clk);
    word_len = 2'd3; bus_width = 2'd3; trim18 = 1'b0; byte_mask = 4'h7;
    word_data = 32'h00ABCDEF; word_valid = 1'b1; pix_ready = 1'b0;
    @(negedge clk);
    word_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      chk("R10 stall data", pix_data, 24'hABCDEF);
      chk("R10 stall valid", {23'b0, pix_valid}, 24'd1);
      @(negedge clk);
    end
    pix_ready = 1'b1;
    @(negedge clk);
    pix_ready = 1'b0;

    // R11: last beat and next word in one cycle
    @(negedge clk);
    word_len = 2'd0; bus_width = 2'd0; byte_mask = 4'hF;
    word_data = 32'h22221111; word_valid = 1'b1;
    @(negedge clk);
    word_data = 32'h44443333;
    chk("R11 first half", pix_data, 24'h001111);
    pix_ready = 1'b1; #1;
    chk("R11 ready low before last", {23'b0, word_ready}, 24'd0);
    @(negedge clk);
    chk("R11 second half", pix_data, 24'h002222);
    chk("R11 ready at last", {23'b0, word_ready}, 24'd1);
    @(negedge clk);
    word_valid = 1'b0;
    chk("R11 no bubble valid", {23'b0, pix_valid}, 24'd1);
    chk("R11 no bubble data", pix_data, 24'h003333);
    @(negedge clk);
    chk("R11 next word high half", pix_data, 24'h004444);
    @(negedge clk);
    pix_ready = 1'b0;
    chk("R11 drained", {23'b0, pix_valid}, 24'd0);

    // R12: settings captured with the word
    @(negedge clk);
    word_len = 2'd0; bus_width = 2'd0; trim18 = 1'b0; byte_mask = 4'hF;
    word_data = 32'h5555AAAA; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    word_len = 2'd3; bus_width = 2'd3; byte_mask = 4'h7; #1;
    chk("R12 first pixel keeps format", pix_data, 24'h00AAAA);
    pix_ready = 1'b1;
    @(negedge clk);
    chk("R12 second pixel keeps count", {23'b0, pix_valid}, 24'd1);
    chk("R12 second pixel keeps format", pix_data, 24'h005555);
    @(negedge clk);
    pix_ready = 1'b0;
    chk("R12 word done", {23'b0, pix_valid}, 24'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule